// File: doc/BRIEF.md
# Entropy Source Health Test Monitor

This block watches raw entropy bits while they are sampled. Ten bit streams arrive in parallel on a shared sample strobe: one combined stream and nine single-oscillator streams. Each stream has two tests. The first is a run-length test that catches a stream stuck at one value. The second is a windowed bias test that catches a stream whose first sample in a window recurs too often. A failure sets a sticky per-stream bit for its test kind and raises the seed-error status. While that status is up, generation is blocked.

After reset or a soft reset, the monitor runs a startup phase of one full window of samples. Generation is allowed only once that phase has passed. A per-oscillator mask removes unhealthy oscillators from the tests. An auto-recover mode restarts the startup phase after a failure and records only the first failure. The manual mode keeps the error status up until software issues a soft reset. Software clears the latched status and the error vectors by writing 0 to the clear port.

Top module: `entropy_health_mon`

## Requirements
- R1: The run test fails on a sample that extends a run of equal values to more than 28 (REP_LIMIT) samples; a run of exactly 28 equal samples does not fail.
- R2: The bias test splits each stream into consecutive windows of 1024 (WIN_LEN) samples. It fails when the window's first sample value occurs more than 684 (PROP_LIMIT) times within that window.
- R3: Failures are recorded in two 10-bit sticky vectors, `repErr` for the run test and `propErr` for the bias test. Bit 0 is the combined stream and bit i (1..9) is oscillator i, driven on `rawBits[i]`.
- R4: When `oscMask[i-1]` is 0, oscillator i can never set an error bit and never raises the seed-error status. Bit 0 is always tested.
- R5: `startupDone` rises on the edge that takes the 1024th sample after reset or a restart. `genAllowed` is high only while `startupDone` is 1 and `seedErrNow` is 0.
- R6: Any unmasked failure sets `seedErrNow` and `seedErrLatched` on the same edge that takes the failing sample.
- R7: A clear write with `clrValue` 0 clears `seedErrLatched`, `repErr` and `propErr`. A clear write with `clrValue` 1 changes nothing. A failure on the same edge still sets the latched status.
- R8: With `autoResetDis` 0, a failure restarts all counters and the startup phase. Only the failures of the first failing edge are stored while both vectors are clear. `seedErrNow` clears when the restarted startup phase completes.
- R9: With `autoResetDis` 1, failures accumulate in the vectors and `seedErrNow` stays set until a soft reset.
- R10: `softReset` clears `seedErrNow` and `startupDone` and restarts every run and window counter. The next sample starts a new run and a new window. The vectors and the latched status are kept.
- R11: A sample is taken only on a cycle where `sampleStb` and `enable` are both 1 and `softReset` is 0. Other cycles change no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Monitor enable; gates sampling |
| sampleStb | input | 1 | Marks a cycle carrying new raw bits |
| rawBits | input | 10 | Bit 0 is the combined stream; bits 9:1 are oscillators 1..9 |
| oscMask | input | 9 | 1 keeps oscillator i+1 under test; 0 masks it |
| autoResetDis | input | 1 | 1 selects manual recovery; 0 selects auto-recover |
| softReset | input | 1 | Restarts the counters and the startup phase |
| clrWrite | input | 1 | Status write strobe |
| clrValue | input | 1 | Value written to the latched seed-error bit |
| repErr | output | 10 | Sticky run-test failures per stream |
| propErr | output | 10 | Sticky bias-test failures per stream |
| seedErrNow | output | 1 | Current seed-error status |
| seedErrLatched | output | 1 | Latched seed-error status |
| startupDone | output | 1 | Startup phase completed |
| genAllowed | output | 1 | Generation permitted |

## Verification
The assertions assume that `oscMask` and `autoResetDis` are quasi-static. They may change only between samples, so a new error bit can be judged against the mask of the previous cycle. The assertions also assume that `softReset` is a single-cycle pulse. The stimulus changes mode and mask only at scenario boundaries. It pulses `softReset` for exactly one cycle. On healthy streams it uses uniform random bits, where an accidental 29-sample run or a 685-of-1024 bias has negligible probability. Faults come from explicit stuck and periodic patterns.

// File: rtl/hmon_pkg.sv
package hmon_pkg;
  typedef struct packed {
    logic restart;   // clear all run/window counters this edge
    logic sampleEn;  // take the current raw bits as a sample
  } hmonCtl_t;
endpackage

// File: rtl/hmon_stream.sv
module hmon_stream
  import hmon_pkg::*;
#(
  parameter int REP_LIMIT  = 28,
  parameter int WIN_LEN    = 1024,
  parameter int PROP_LIMIT = 684
) (
  input  logic     clk,
  input  logic     rstN,
  input  hmonCtl_t ctl,
  input  logic     sampleBit,
  input  logic     active,
  output logic     repFail,
  output logic     propFail
);
  localparam int RW = $clog2(REP_LIMIT + 2);
  localparam int WW = $clog2(WIN_LEN);
  localparam int MW = $clog2(PROP_LIMIT + 2);
  localparam logic [RW-1:0] REP_TOP  = RW'(REP_LIMIT);
  localparam logic [MW-1:0] PROP_TOP = MW'(PROP_LIMIT);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_LEN - 1);

  logic [RW-1:0] runCnt;
  logic          lastBit;
  logic [WW-1:0] winCnt;
  logic          refBit;
  logic [MW-1:0] matchCnt;
  logic          sameRun, winFirst, sameRef;

  assign sameRun  = (runCnt != '0) && (sampleBit == lastBit);
  assign winFirst = (winCnt == '0);
  assign sameRef  = !winFirst && (sampleBit == refBit);
  assign repFail  = active && ctl.sampleEn && sameRun && (runCnt == REP_TOP);
  assign propFail = active && ctl.sampleEn && sameRef && (matchCnt == PROP_TOP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt   <= '0;
      lastBit  <= 1'b0;
      winCnt   <= '0;
      refBit   <= 1'b0;
      matchCnt <= '0;
    end else if (ctl.restart) begin
      runCnt   <= '0;
      winCnt   <= '0;
      matchCnt <= '0;
    end else if (ctl.sampleEn) begin
      lastBit <= sampleBit;
      if (!sameRun) runCnt <= RW'(1);
      else if (runCnt <= REP_TOP) runCnt <= runCnt + RW'(1);
      winCnt <= (winCnt == WIN_LAST) ? '0 : winCnt + WW'(1);
      if (winFirst) begin
        refBit   <= sampleBit;
        matchCnt <= MW'(1);
      end else if (sameRef && (matchCnt <= PROP_TOP)) begin
        matchCnt <= matchCnt + MW'(1);
      end
    end
  end
endmodule

// File: rtl/hmon_datapath.sv
module hmon_datapath
  import hmon_pkg::*;
#(
  parameter int NUM_STREAMS = 10,
  parameter int REP_LIMIT   = 28,
  parameter int WIN_LEN     = 1024,
  parameter int PROP_LIMIT  = 684
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  hmonCtl_t               ctl,
  input  logic [NUM_STREAMS-1:0] rawBits,
  input  logic [NUM_STREAMS-1:0] streamMask,
  output logic [NUM_STREAMS-1:0] repFail,
  output logic [NUM_STREAMS-1:0] propFail
);
  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    hmon_stream #(
      .REP_LIMIT (REP_LIMIT),
      .WIN_LEN   (WIN_LEN),
      .PROP_LIMIT(PROP_LIMIT)
    ) u_stream (
      .clk      (clk),
      .rstN     (rstN),
      .ctl      (ctl),
      .sampleBit(rawBits[s]),
      .active   (streamMask[s]),
      .repFail  (repFail[s]),
      .propFail (propFail[s])
    );
  end
endmodule

// File: rtl/hmon_control.sv
module hmon_control
  import hmon_pkg::*;
#(
  parameter int NUM_STREAMS     = 10,
  parameter int STARTUP_SAMPLES = 1024
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   enable,
  input  logic                   sampleStb,
  input  logic                   softReset,
  input  logic                   autoResetDis,
  input  logic                   clrWrite,
  input  logic                   clrValue,
  input  logic [NUM_STREAMS-1:0] repFail,
  input  logic [NUM_STREAMS-1:0] propFail,
  output hmonCtl_t               ctl,
  output logic [NUM_STREAMS-1:0] repErr,
  output logic [NUM_STREAMS-1:0] propErr,
  output logic                   seedErrNow,
  output logic                   seedErrLatched,
  output logic                   startupDone
);
  localparam int SW = $clog2(STARTUP_SAMPLES + 1);
  localparam logic [SW-1:0] START_LAST = SW'(STARTUP_SAMPLES - 1);

  logic [SW-1:0]          startCnt;
  logic                   anyFail, clrNow, startDoneEvt, capture;
  logic [NUM_STREAMS-1:0] repBase, propBase;

  assign anyFail      = (|repFail) || (|propFail);
  assign ctl.sampleEn = sampleStb && enable && !softReset;
  assign ctl.restart  = softReset || (!autoResetDis && anyFail);
  assign startDoneEvt = ctl.sampleEn && !startupDone && !ctl.restart
                        && (startCnt == START_LAST);
  assign clrNow       = clrWrite && !clrValue;
  assign repBase      = clrNow ? '0 : repErr;
  assign propBase     = clrNow ? '0 : propErr;
  assign capture      = autoResetDis || ((repBase == '0) && (propBase == '0));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startCnt       <= '0;
      startupDone    <= 1'b0;
      seedErrNow     <= 1'b0;
      seedErrLatched <= 1'b0;
      repErr         <= '0;
      propErr        <= '0;
    end else begin
      if (ctl.restart) begin
        startCnt    <= '0;
        startupDone <= 1'b0;
      end else if (ctl.sampleEn && !startupDone) begin
        startCnt <= startCnt + SW'(1);
        if (startDoneEvt) startupDone <= 1'b1;
      end
      if (softReset) seedErrNow <= 1'b0;
      else if (anyFail) seedErrNow <= 1'b1;
      else if (startDoneEvt && !autoResetDis) seedErrNow <= 1'b0;
      seedErrLatched <= anyFail || (seedErrLatched && !clrNow);
      repErr  <= repBase  | (capture ? repFail  : '0);
      propErr <= propBase | (capture ? propFail : '0);
    end
  end
endmodule

// File: rtl/entropy_health_mon.sv
module entropy_health_mon
  import hmon_pkg::*;
#(
  parameter int NUM_OSC         = 9,
  parameter int REP_LIMIT       = 28,
  parameter int WIN_LEN         = 1024,
  parameter int PROP_LIMIT      = 684,
  parameter int STARTUP_SAMPLES = WIN_LEN
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             sampleStb,
  input  logic [NUM_OSC:0] rawBits,
  input  logic [NUM_OSC-1:0] oscMask,
  input  logic             autoResetDis,
  input  logic             softReset,
  input  logic             clrWrite,
  input  logic             clrValue,
  output logic [NUM_OSC:0] repErr,
  output logic [NUM_OSC:0] propErr,
  output logic             seedErrNow,
  output logic             seedErrLatched,
  output logic             startupDone,
  output logic             genAllowed
);
  localparam int NUM_STREAMS = NUM_OSC + 1;

  hmonCtl_t               ctl;
  logic [NUM_STREAMS-1:0] repFail, propFail;

  hmon_control #(
    .NUM_STREAMS    (NUM_STREAMS),
    .STARTUP_SAMPLES(STARTUP_SAMPLES)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .enable        (enable),
    .sampleStb     (sampleStb),
    .softReset     (softReset),
    .autoResetDis  (autoResetDis),
    .clrWrite      (clrWrite),
    .clrValue      (clrValue),
    .repFail       (repFail),
    .propFail      (propFail),
    .ctl           (ctl),
    .repErr        (repErr),
    .propErr       (propErr),
    .seedErrNow    (seedErrNow),
    .seedErrLatched(seedErrLatched),
    .startupDone   (startupDone)
  );

  hmon_datapath #(
    .NUM_STREAMS(NUM_STREAMS),
    .REP_LIMIT  (REP_LIMIT),
    .WIN_LEN    (WIN_LEN),
    .PROP_LIMIT (PROP_LIMIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .rawBits   (rawBits),
    .streamMask({oscMask, 1'b1}),
    .repFail   (repFail),
    .propFail  (propFail)
  );

  assign genAllowed = startupDone && !seedErrNow;
endmodule

// File: rtl/hmon_checker.sv
module hmon_checker #(
  parameter int NUM_OSC = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             sampleStb,
  input logic [NUM_OSC-1:0] oscMask,
  input logic             autoResetDis,
  input logic             softReset,
  input logic             clrWrite,
  input logic             clrValue,
  input logic [NUM_OSC:0] repErr,
  input logic [NUM_OSC:0] propErr,
  input logic             seedErrNow,
  input logic             seedErrLatched,
  input logic             startupDone
);
  // R6: a newly set error bit comes with both seed-error flags
  assert_new_err_flags_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((|(repErr & ~$past(repErr))) || (|(propErr & ~$past(propErr))))
      |-> (seedErrNow && seedErrLatched));

  // R4: masked oscillators never gain an error bit
  assert_mask_blocks_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((((repErr & ~$past(repErr)) | (propErr & ~$past(propErr)))
      & {~$past(oscMask), 1'b0}) == '0));

  // R11: startup completes only on an accepted sample
  assert_startup_on_sample_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startupDone) |-> $past(sampleStb && enable && !softReset));

  // R7: latched status drops only after a clear write of 0
  assert_latched_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(seedErrLatched) |-> $past(clrWrite && !clrValue));

  // R9: in manual mode the current status drops only through a soft reset
  assert_manual_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(seedErrNow) && $past(autoResetDis)) |-> $past(softReset));

  // R10: a soft reset withdraws the startup pass
  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(softReset) |-> !startupDone);
endmodule

bind entropy_health_mon hmon_checker #(.NUM_OSC(NUM_OSC)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .enable        (enable),
  .sampleStb     (sampleStb),
  .oscMask       (oscMask),
  .autoResetDis  (autoResetDis),
  .softReset     (softReset),
  .clrWrite      (clrWrite),
  .clrValue      (clrValue),
  .repErr        (repErr),
  .propErr       (propErr),
  .seedErrNow    (seedErrNow),
  .seedErrLatched(seedErrLatched),
  .startupDone   (startupDone)
);

// File: tb/tb_entropy_health_mon.sv
module tb_entropy_health_mon;
  localparam int CLK_PERIOD = 10;
  localparam int NS   = 10;
  localparam int REPL = 28;
  localparam int WINL = 1024;
  localparam int PROPL = 684;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, sampleStb = 1'b0, autoResetDis = 1'b1;
  logic softReset = 1'b0, clrWrite = 1'b0, clrValue = 1'b1;
  logic [9:0] rawBits = '0;
  logic [8:0] oscMask = 9'b111101111;
  logic [9:0] repErr, propErr;
  logic seedErrNow, seedErrLatched, startupDone, genAllowed;

  int checks = 0, errors = 0, cycles = 0;
  int mode [NS];   // 0 random, 1 stuck0, 2 stuck1, 3 pattern 1110
  int patCnt = 0;

  // reference model state
  int runC [NS], lastB [NS], winC [NS], refB [NS], matchC [NS];
  logic [9:0] mRep = '0, mProp = '0;
  logic mNow = 0, mLat = 0, mDone = 0;
  int mStart = 0;

  entropy_health_mon dut (
    .clk(clk), .rstN(rstN), .enable(enable), .sampleStb(sampleStb),
    .rawBits(rawBits), .oscMask(oscMask), .autoResetDis(autoResetDis),
    .softReset(softReset), .clrWrite(clrWrite), .clrValue(clrValue),
    .repErr(repErr), .propErr(propErr), .seedErrNow(seedErrNow),
    .seedErrLatched(seedErrLatched), .startupDone(startupDone),
    .genAllowed(genAllowed));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference, updated on every rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NS; i++) begin
        runC[i] = 0; lastB[i] = 0; winC[i] = 0; refB[i] = 0; matchC[i] = 0;
      end
      mRep = '0; mProp = '0; mNow = 0; mLat = 0; mDone = 0; mStart = 0;
    end else begin
      logic [9:0] fr, fp, baseR, baseP;
      bit sEn, rst, anyF, clr, cap, doneEvt;
      sEn = sampleStb && enable && !softReset;
      for (int i = 0; i < NS; i++) begin
        bit act;
        int b;
        act = (i == 0) || oscMask[i-1];
        b = rawBits[i];
        fr[i] = act && sEn && runC[i] != 0 && b == lastB[i] && runC[i] == REPL;
        fp[i] = act && sEn && winC[i] != 0 && b == refB[i] && matchC[i] == PROPL;
      end
      anyF = (fr != 0) || (fp != 0);
      rst = softReset || (!autoResetDis && anyF);
      doneEvt = sEn && !mDone && !rst && mStart == WINL - 1;
      for (int i = 0; i < NS; i++) begin
        int b;
        b = rawBits[i];
        if (rst) begin
          runC[i] = 0; winC[i] = 0; matchC[i] = 0;
        end else if (sEn) begin
          if (runC[i] != 0 && b == lastB[i]) begin
            if (runC[i] <= REPL) runC[i]++;
          end else runC[i] = 1;
          lastB[i] = b;
          if (winC[i] == 0) begin
            refB[i] = b; matchC[i] = 1;
          end else if (b == refB[i] && matchC[i] <= PROPL) matchC[i]++;
          winC[i] = (winC[i] == WINL - 1) ? 0 : winC[i] + 1;
        end
      end
      if (rst) begin mStart = 0; mDone = 0; end
      else if (sEn && !mDone) begin mStart++; if (doneEvt) mDone = 1; end
      if (softReset) mNow = 0;
      else if (anyF) mNow = 1;
      else if (doneEvt && !autoResetDis) mNow = 0;
      clr = clrWrite && !clrValue;
      mLat = anyF || (mLat && !clr);
      baseR = clr ? '0 : mRep;
      baseP = clr ? '0 : mProp;
      cap = autoResetDis || (baseR == 0 && baseP == 0);
      mRep = baseR | (cap ? fr : '0);
      mProp = baseP | (cap ? fp : '0);
    end
  end

  // compare against the model away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check(repErr == mRep, "R1 repErr", 32'(repErr), 32'(mRep));
      check(propErr == mProp, "R2 propErr", 32'(propErr), 32'(mProp));
      check(seedErrNow == mNow, "R6 seedErrNow", 32'(seedErrNow), 32'(mNow));
      check(seedErrLatched == mLat, "R7 seedErrLatched", 32'(seedErrLatched), 32'(mLat));
      check(startupDone == mDone, "R5 startupDone", 32'(startupDone), 32'(mDone));
      check(genAllowed == (mDone && !mNow), "R5 genAllowed", 32'(genAllowed),
            32'(mDone && !mNow));
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R5 watchdog expired actual %0d expected 0", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [9:0] genBits();
    logic [9:0] v;
    for (int i = 0; i < NS; i++) begin
      case (mode[i])
        1: v[i] = 1'b0;
        2: v[i] = 1'b1;
        3: v[i] = (patCnt % 4) != 3;
        default: v[i] = 1'($urandom());
      endcase
    end
    return v;
  endfunction

  task automatic step(input int n);
    repeat (n) begin
      rawBits = genBits();
      @(negedge clk);
      patCnt++;
    end
  endtask

  task automatic pulseSoftReset();
    softReset = 1'b1; step(1); softReset = 1'b0;
  endtask

  task automatic clearWrite(input logic v);
    clrWrite = 1'b1; clrValue = v; step(1); clrWrite = 1'b0; clrValue = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < NS; i++) mode[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(repErr == 0 && propErr == 0 && !seedErrNow && !seedErrLatched && !genAllowed,
          "R5 reset state", 32'({repErr, propErr}), 32'd0);

    // manual mode, healthy streams: startup passes
    enable = 1'b1; sampleStb = 1'b1; autoResetDis = 1'b1;
    step(WINL + 20);
    check(genAllowed == 1'b1, "R5 startup pass", 32'(genAllowed), 32'd1);

    // disabled: stuck bits are not sampled
    enable = 1'b0; mode[3] = 1; mode[5] = 1;
    step(60);
    check(repErr == 0 && !seedErrNow, "R11 disabled ignores samples", 32'(repErr), 32'd0);
    enable = 1'b1; sampleStb = 1'b0;
    step(60);
    check(repErr == 0, "R11 no strobe ignores samples", 32'(repErr), 32'd0);
    sampleStb = 1'b1;
    step(50);
    check(repErr[3] == 1'b1, "R3 oscillator 3 run failure bit", 32'(repErr), 32'h8);
    check(repErr[5] == 1'b0, "R4 masked oscillator 5 silent", 32'(repErr), 32'h8);
    check(seedErrNow && seedErrLatched && !genAllowed, "R6 seed error raised",
          32'({seedErrNow, seedErrLatched}), 32'h3);

    // clear writes
    mode[3] = 0; mode[5] = 0;
    clearWrite(1'b1);
    check(seedErrLatched && repErr[3], "R7 write 1 no effect", 32'(seedErrLatched), 32'd1);
    clearWrite(1'b0);
    check(!seedErrLatched && repErr == 0 && propErr == 0, "R7 write 0 clears",
          32'(seedErrLatched), 32'd0);
    step(40);
    check(seedErrNow == 1'b1, "R9 manual mode holds error", 32'(seedErrNow), 32'd1);
    pulseSoftReset();
    check(!seedErrNow && !startupDone, "R10 soft reset restarts", 32'(seedErrNow), 32'd0);

    // exact run boundary after soft reset
    mode[7] = 2;
    step(REPL);
    check(repErr == 0, "R1 run of 28 passes", 32'(repErr), 32'd0);
    step(1);
    check(repErr[7] == 1'b1, "R1 run of 29 fails", 32'(repErr), 32'h80);

    // bias window on oscillator 2
    mode[7] = 0;
    clearWrite(1'b0);
    mode[2] = 3;
    pulseSoftReset();
    patCnt = 0;
    step(WINL);
    check(propErr[2] == 1'b1 && repErr == 0, "R2 biased window fails",
          32'(propErr), 32'h4);

    // auto-recover mode
    mode[2] = 0;
    clearWrite(1'b0);
    autoResetDis = 1'b0;
    pulseSoftReset();
    step(WINL + 10);
    check(genAllowed == 1'b1, "R8 auto mode startup pass", 32'(genAllowed), 32'd1);
    mode[0] = 1;
    step(40);
    mode[0] = 0; mode[4] = 2;
    step(40);
    check(repErr == 10'h001 && propErr == 0, "R8 only first failure kept",
          32'(repErr), 32'h1);
    check(seedErrNow && !startupDone, "R8 failure restarts startup",
          32'({seedErrNow, startupDone}), 32'h2);
    mode[4] = 0;
    step(WINL + 10);
    check(!seedErrNow && genAllowed, "R8 auto recovery clears status",
          32'(seedErrNow), 32'd0);
    check(seedErrLatched == 1'b1, "R7 latched survives recovery",
          32'(seedErrLatched), 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule